// File: doc/BRIEF.md
# Bipolar Line Code Encoder

This block turns a serial transmit bit stream into the two pulse rails that a line interface unit needs. One rail carries positive pulses and the other carries negative pulses. Both rails low means no pulse. Two run-time controls pick the coding.

- **Unipolar:** the data passes straight through on the positive rail.
- **Bipolar with plain alternate mark inversion (AMI):** each one bit becomes a pulse whose polarity is opposite to the pulse before it.
- **Bipolar with HDB3:** as AMI, but every run of four zeros is replaced by a substitution code. This keeps enough transitions on the line for the far end to recover the clock.

HDB3 must see four bits ahead before it commits a symbol. Every bit therefore passes through a four-stage window. All modes share that window, so the latency is the same constant in every mode, and the output stream stays aligned across a mode switch. When the selected coding changes, the pulse-polarity and substitution state restart from their reset values.

Top module: `line_code_encoder`

## Requirements
- R1: `unipolar_sel` = 1 selects unipolar coding, whatever the value of `hdb3_sel`. With `unipolar_sel` = 0 the coding is bipolar: `hdb3_sel` = 0 selects AMI and `hdb3_sel` = 1 selects HDB3.
- R2: While `rst_n` is low, and during the first four clocks after its release, both rails are low.
- R3: In AMI mode every one bit becomes a pulse whose polarity is opposite to the previous pulse, however many zeros lie between them. The first pulse after reset or after a coding change is positive.
- R4: A pulse is shown as `pos_out` = 1 (positive) or `neg_out` = 1 (negative). A space is shown as both rails low. The two rails are never high in the same cycle.
- R5: In unipolar mode `pos_out` carries the delayed data bit and `neg_out` stays low.
- R6: In HDB3 mode each run of four zeros is coded in one of two ways, counting normal pulses sent since the last violation:
  - If that count is odd, the run becomes three spaces and then a violation.
  - If the count is even (including none since reset), the run becomes an alternating pulse, two spaces and then a violation.
  - A violation has the same polarity as the pulse just before it.
- R7: In every mode, a bit sampled at clock edge k sets the rails after edge k+4.
- R8: At a clock edge where the selected coding differs from the one selected at the previous edge, the symbol leaving at that edge is coded under the new mode. The polarity, parity and substitution state used for it restart from their reset values.
- R9: In HDB3 mode the rails never show more than three consecutive spaces. Successive violations alternate in polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line clock; every port is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| data_in | input | 1 | Serial transmit data, one bit per clock |
| unipolar_sel | input | 1 | 1 selects unipolar pass-through, 0 selects bipolar coding |
| hdb3_sel | input | 1 | In bipolar mode: 1 selects HDB3, 0 selects AMI |
| pos_out | output | 1 | Positive pulse rail |
| neg_out | output | 1 | Negative pulse rail |

## Verification
Each test stream is compared symbol by symbol, at the four-clock latency, against an expected sequence built from the coding rules.

- **All ones:** separates correct alternation and start polarity from a stuck or inverted polarity state.
- **Mixed marks and zero runs of four, five and eight:** exercises both substitution forms in turn, and would expose a wrong parity rule or a wrong violation polarity.
- **All zeros:** checks that back-to-back substitutions flip polarity.
- **Short stream forcing three spaces then a violation:** checks the odd-count case directly.
- **Unipolar stream with `hdb3_sel` held high:** shows that unipolar mode overrides the code select.
- **AMI stream that switches to HDB3 mid-way:** shows the coding state restarting at the switch, because the first pulse after it must be positive even though the AMI run ended on a positive pulse.

// File: rtl/lce_pkg.sv
`timescale 1ns/1ps
// Package: shared symbol and coding-mode types for the line code encoder.
// Assumes: three line symbols (space, positive, negative); unipolar overrides the code select.
package lce_pkg;

    typedef enum logic [1:0] {
        SYM_SPACE = 2'd0,
        SYM_POS   = 2'd1,
        SYM_NEG   = 2'd2
    } sym_t;

    typedef enum logic [1:0] {
        CODE_AMI  = 2'd0,
        CODE_HDB3 = 2'd1,
        CODE_UNI  = 2'd2
    } code_t;

    // Map the two mode pins to a coding mode; unipolar wins.
    function automatic code_t decode_mode(input logic uni, input logic hdb3);
        if (uni) begin
            return CODE_UNI;
        end
        return hdb3 ? CODE_HDB3 : CODE_AMI;
    endfunction

    // Polarity of the next alternating pulse, given whether the last one was positive.
    function automatic sym_t next_mark(input logic last_pos);
        return last_pos ? SYM_NEG : SYM_POS;
    endfunction

endpackage

// File: rtl/lce_delay_line.sv
`timescale 1ns/1ps
// Module: lce_delay_line
// Shifts the serial input through DEPTH stages and exposes the whole window,
// oldest bit at index DEPTH-1, with a per-stage valid flag cleared by reset.
// Assumes: one new bit per clock, synchronous active-low reset.
module lce_delay_line #(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    output logic [DEPTH-1:0] win,
    output logic [DEPTH-1:0] vld
);

    generate
        if (DEPTH == 1) begin : g_single
            // Single stage: hold the last bit and mark it valid.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    win <= '0;
                    vld <= '0;
                end else begin
                    win <= din;
                    vld <= 1'b1;
                end
            end
        end else begin : g_shift
            // Shift chain: newest bit enters at index 0.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    win <= '0;
                    vld <= '0;
                end else begin
                    win <= {win[DEPTH-2:0], din};
                    vld <= {vld[DEPTH-2:0], 1'b1};
                end
            end
        end
    endgenerate

endmodule

// File: rtl/lce_mode_track.sv
`timescale 1ns/1ps
// Module: lce_mode_track
// Decodes the mode pins and flags any edge at which the decoded coding mode
// differs from the one seen at the previous edge.
// Assumes: reset value is bipolar AMI.
module lce_mode_track
    import lce_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  unipolar_sel,
    input  logic  hdb3_sel,
    output code_t code,
    output logic  code_chg
);

    code_t code_q;

    // Decode the pins and compare against the previously seen mode.
    always_comb begin
        code     = decode_mode(unipolar_sel, hdb3_sel);
        code_chg = (code != code_q);
    end

    // Remember the mode for the next comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= CODE_AMI;
        end else begin
            code_q <= code;
        end
    end

endmodule

// File: rtl/lce_symbol_coder.sv
`timescale 1ns/1ps
// Module: lce_symbol_coder
// Picks the line symbol for the oldest window bit: unipolar pass, AMI
// alternation, or HDB3 with substitution of RUN_LEN-zero runs.
// State: polarity of last pulse, parity of normal pulses since last
// violation, position inside an active substitution.
// Assumes: window oldest bit at index RUN_LEN-1; state restarts on a mode change.
module lce_symbol_coder
    import lce_pkg::*;
#(
    parameter int RUN_LEN = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RUN_LEN-1:0] win,
    input  logic [RUN_LEN-1:0] vld,
    input  code_t              code,
    input  logic               code_chg,
    output sym_t               sym
);

    localparam int CNT_W = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(RUN_LEN - 1);

    logic             last_pos_q, last_pos_d;
    logic             odd_q, odd_d;
    logic [CNT_W-1:0] sub_q, sub_d;

    logic             eff_last, eff_odd;
    logic [CNT_W-1:0] eff_sub;
    logic             oldest_one, run_zero;

    // Symbol choice and next state for the bit leaving the window.
    always_comb begin
        eff_last   = code_chg ? 1'b0 : last_pos_q;
        eff_odd    = code_chg ? 1'b0 : odd_q;
        eff_sub    = code_chg ? '0   : sub_q;
        oldest_one = win[RUN_LEN-1] & vld[RUN_LEN-1];
        run_zero   = (win == '0) && (&vld);

        sym        = SYM_SPACE;
        last_pos_d = eff_last;
        odd_d      = eff_odd;
        sub_d      = eff_sub;

        case (code)
            CODE_UNI: begin
                if (oldest_one) begin
                    sym = SYM_POS;
                end
            end
            CODE_AMI: begin
                if (oldest_one) begin
                    sym        = next_mark(eff_last);
                    last_pos_d = ~eff_last;
                    odd_d      = ~eff_odd;
                end
            end
            default: begin
                if (eff_sub == LAST_POS) begin
                    sym   = eff_last ? SYM_POS : SYM_NEG;
                    odd_d = 1'b0;
                    sub_d = '0;
                end else if (eff_sub != '0) begin
                    sub_d = eff_sub + 1'b1;
                end else if (run_zero) begin
                    sub_d = CNT_W'(1);
                    if (!eff_odd) begin
                        sym        = next_mark(eff_last);
                        last_pos_d = ~eff_last;
                    end
                end else if (oldest_one) begin
                    sym        = next_mark(eff_last);
                    last_pos_d = ~eff_last;
                    odd_d      = ~eff_odd;
                end
            end
        endcase
    end

    // Coding state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_pos_q <= 1'b0;
            odd_q      <= 1'b0;
            sub_q      <= '0;
        end else begin
            last_pos_q <= last_pos_d;
            odd_q      <= odd_d;
            sub_q      <= sub_d;
        end
    end

endmodule

// File: rtl/lce_rail_driver.sv
`timescale 1ns/1ps
// Module: lce_rail_driver
// Registers the chosen symbol onto the two pulse rails.
// Assumes: a symbol never asks for both rails.
module lce_rail_driver
    import lce_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  sym_t sym,
    output logic pos_out,
    output logic neg_out
);

    // Rail output registers, low in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_out <= 1'b0;
            neg_out <= 1'b0;
        end else begin
            pos_out <= (sym == SYM_POS);
            neg_out <= (sym == SYM_NEG);
        end
    end

endmodule

// File: rtl/line_code_encoder.sv
`timescale 1ns/1ps
// Module: line_code_encoder (top)
// Serial data to dual-rail line pulses with unipolar, AMI or HDB3 coding.
// Latency is LATENCY clocks from sampling edge to rail update in all modes.
// Assumes: synchronous active-low reset, mode pins sampled every clock.
module line_code_encoder
    import lce_pkg::*;
#(
    parameter int RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic data_in,
    input  logic unipolar_sel,
    input  logic hdb3_sel,
    output logic pos_out,
    output logic neg_out
);

    localparam int LATENCY = RUN_LEN;

    logic [LATENCY-1:0] win;
    logic [LATENCY-1:0] vld;
    code_t              code;
    logic               code_chg;
    sym_t               sym;

    lce_delay_line #(.DEPTH(LATENCY)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (data_in),
        .win   (win),
        .vld   (vld)
    );

    lce_mode_track u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .unipolar_sel (unipolar_sel),
        .hdb3_sel     (hdb3_sel),
        .code         (code),
        .code_chg     (code_chg)
    );

    lce_symbol_coder #(.RUN_LEN(LATENCY)) u_coder (
        .clk      (clk),
        .rst_n    (rst_n),
        .win      (win),
        .vld      (vld),
        .code     (code),
        .code_chg (code_chg),
        .sym      (sym)
    );

    lce_rail_driver u_rails (
        .clk     (clk),
        .rst_n   (rst_n),
        .sym     (sym),
        .pos_out (pos_out),
        .neg_out (neg_out)
    );

endmodule

// File: rtl/lce_checker.sv
`timescale 1ns/1ps
// Module: lce_checker
// Port-level properties of the line code encoder, attached by bind.
// Assumes: four-clock latency; a symbol on the rails at edge E was coded at E-1.
module lce_checker (
    input logic clk,
    input logic rst_n,
    input logic data_in,
    input logic unipolar_sel,
    input logic hdb3_sel,
    input logic pos_out,
    input logic neg_out
);

    logic [2:0] since_rst;
    logic [1:0] mode_d, mode_dd;
    logic [2:0] zrun;
    logic       sym_zero, warm, hdb3_d, same_d;

    always_comb begin
        sym_zero = !pos_out && !neg_out;
        warm     = (since_rst >= 3'd5);
        hdb3_d   = (mode_d == 2'b01);
        same_d   = (mode_d == mode_dd);
    end

    // Cycles since reset release (saturating), mode history, HDB3 space run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
            mode_d    <= '0;
            mode_dd   <= '0;
            zrun      <= '0;
        end else begin
            if (since_rst != 3'd7) begin
                since_rst <= since_rst + 3'd1;
            end
            mode_d  <= {unipolar_sel, hdb3_sel};
            mode_dd <= mode_d;
            if (warm && sym_zero && hdb3_d) begin
                if (!same_d) begin
                    zrun <= 3'd1;
                end else if (zrun != 3'd7) begin
                    zrun <= zrun + 3'd1;
                end
            end else begin
                zrun <= '0;
            end
        end
    end

    AST_RAILS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pos_out && neg_out)); // R4

    AST_WARMUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst <= 3'd4) |-> sym_zero); // R2

    AST_UNI_NEG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd1 && $past(unipolar_sel)) |-> !neg_out); // R5

    AST_UNI_PASS_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd5 && $past(unipolar_sel)) |-> (pos_out == $past(data_in, 5))); // R7

    AST_HDB3_SPACE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && sym_zero && hdb3_d && same_d) |-> (zrun < 3'd3)); // R9

endmodule

bind line_code_encoder lce_checker u_lce_checker (.*);

// File: tb/line_code_encoder_bench.sv
`timescale 1ns/1ps
// Bench: directed scenarios for line_code_encoder, one task per scenario.
module line_code_encoder_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic data_in = 1'b0;
    logic unipolar_sel = 1'b0;
    logic hdb3_sel = 1'b0;
    logic pos_out, neg_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int bits [80];
    int exp_s [80];
    int got [80];

    line_code_encoder u_line_code_encoder (
        .clk          (clk),
        .rst_n        (rst_n),
        .data_in      (data_in),
        .unipolar_sel (unipolar_sel),
        .hdb3_sel     (hdb3_sel),
        .pos_out      (pos_out),
        .neg_out      (neg_out)
    );

    always #2 clk = ~clk;

    // Current rail state as +1 / 0 / -1, or 2 when both rails are high.
    function automatic int rail_sym();
        if (pos_out && neg_out) return 2;
        if (pos_out) return 1;
        if (neg_out) return -1;
        return 0;
    endfunction

    task automatic check(input string req, input int actual, input int expected);
        n_cmp++;
        if (actual != expected) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // Mode codes: 0 AMI, 1 HDB3, 2 unipolar, 3 unipolar with hdb3_sel high.
    task automatic set_mode(input int m);
        unipolar_sel = (m >= 2);
        hdb3_sel     = (m == 1) || (m == 3);
    endtask

    task automatic load(input int n, input logic [63:0] v);
        for (int i = 0; i < 80; i++) begin
            bits[i] = 0; exp_s[i] = 0; got[i] = 0;
        end
        for (int i = 0; i < n; i++) bits[i] = int'(v[n-1-i]);
    endtask

    // Expected symbols for bits[start..stop-1] under mode m with fresh state.
    task automatic model(input int start, input int stop, input int m);
        int last = -1;
        int par = 0;
        int i = start;
        while (i < stop) begin
            if (m >= 2) begin
                exp_s[i] = bits[i]; i++;
            end else if (m == 1 && bits[i] == 0 && bits[i+1] == 0 &&
                         bits[i+2] == 0 && bits[i+3] == 0) begin
                if (par % 2 == 1) begin
                    exp_s[i] = 0;
                end else begin
                    last = -last; exp_s[i] = last;
                end
                exp_s[i+1] = 0; exp_s[i+2] = 0; exp_s[i+3] = last;
                par = 0; i += 4;
            end else if (bits[i] != 0) begin
                last = -last; exp_s[i] = last; par++; i++;
            end else begin
                exp_s[i] = 0; i++;
            end
        end
    endtask

    // Reset, then stream n bits (zeros after); mode ma, switching to mb so that bit sw is coded under mb.
    task automatic run_stream(input int n, input int ma, input int mb, input int sw);
        set_mode(ma);
        rst_n = 1'b0;
        data_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 rails low in reset", rail_sym(), 0);
        for (int t = 0; t <= n + 4; t++) begin
            @(negedge clk);
            if (t >= 5) got[t-5] = rail_sym();
            else check("R2 rails low warm-up", rail_sym(), 0);
            rst_n = 1'b1;
            if (t >= sw + 4) set_mode(mb);
            data_in = (t < n) ? bits[t][0] : 1'b0;
        end
    endtask

    task automatic compare(input int n, input string req);
        for (int i = 0; i < n; i++) check(req, got[i], exp_s[i]);
    endtask

    task automatic check_alternation(input int lo, input int hi, input string req);
        int last = 0;
        int bad = 0;
        for (int i = lo; i < hi; i++) begin
            if (got[i] != 0) begin
                if (got[i] == last) bad++;
                last = got[i];
            end
        end
        check(req, bad, 0);
    endtask

    task automatic check_hdb3_props(input int lo, input int hi);
        int run = 0;
        int maxrun = 0;
        int prev = 0;
        int lastv = 0;
        int bad = 0;
        for (int i = lo; i < hi; i++) begin
            if (got[i] == 0) begin
                run++;
                if (run > maxrun) maxrun = run;
            end else begin
                run = 0;
                if (got[i] == prev) begin
                    if (lastv != 0 && got[i] == lastv) bad++;
                    lastv = got[i];
                end
                prev = got[i];
            end
        end
        check("R9 longest space run within 3", (maxrun <= 3) ? 1 : 0, 1);
        check("R9 violations alternate", bad, 0);
    endtask

    task automatic t_reset_ones();
        load(8, 64'b11111111);
        for (int i = 0; i < 8; i++) exp_s[i] = (i % 2 == 0) ? 1 : -1;
        run_stream(8, 0, 0, 999);
        compare(8, "R3 R7 all ones start positive");
    endtask

    task automatic t_ami_mixed();
        load(22, 64'b1011000101111000001001);
        model(0, 22, 0);
        run_stream(22, 0, 0, 999);
        compare(22, "R3 R4 R7 AMI mixed");
        check_alternation(0, 22, "R3 AMI alternation");
    endtask

    task automatic t_hdb3_mixed();
        load(35, 64'b1000_0110_0000_1000_0000_0101_0000_1110_000);
        model(0, 35, 1);
        run_stream(35, 1, 1, 999);
        compare(35, "R6 HDB3 mixed runs");
        check_hdb3_props(0, 35);
    endtask

    task automatic t_hdb3_zeros();
        load(16, 64'b0);
        for (int i = 0; i < 16; i++) begin
            int pol = ((i / 4) % 2 == 0) ? 1 : -1;
            exp_s[i] = (i % 4 == 0 || i % 4 == 3) ? pol : 0;
        end
        run_stream(16, 1, 1, 999);
        compare(16, "R6 R1 HDB3 all zeros B00V chain");
        check_hdb3_props(0, 16);
    endtask

    task automatic t_hdb3_odd();
        load(11, 64'b10000110000);
        exp_s[0] = 1;  exp_s[1] = 0; exp_s[2] = 0; exp_s[3] = 0; exp_s[4] = 1;
        exp_s[5] = -1; exp_s[6] = 1; exp_s[7] = -1; exp_s[8] = 0; exp_s[9] = 0;
        exp_s[10] = -1;
        run_stream(11, 1, 1, 999);
        compare(11, "R6 HDB3 000V then B00V");
    endtask

    task automatic t_unipolar();
        load(22, 64'b1011000101111000001001);
        model(0, 22, 3);
        run_stream(22, 3, 3, 999);
        compare(22, "R5 R1 unipolar pass with hdb3_sel high");
    endtask

    task automatic t_switch();
        load(20, 64'b1011_1001_1000_0110_0001);
        model(0, 8, 0);
        model(8, 20, 1);
        run_stream(20, 0, 1, 8);
        compare(20, "R8 AMI to HDB3 switch");
        check("R8 first pulse after switch positive", got[8], 1);
        check_hdb3_props(8, 20);
    endtask

    initial begin
        t_reset_ones();
        t_ami_mixed();
        t_hdb3_mixed();
        t_hdb3_zeros();
        t_hdb3_odd();
        t_unipolar();
        t_switch();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run finished)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule